// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 39-bit virtual address into a physical address. It reads page-table entries from memory, one level at a time, and stops at the first entry that is a leaf. A requester supplies the virtual address, the kind of access (load, store or fetch), whether the access comes from user mode, and the current address-translation control word. The walker returns either a physical address or a page-fault flag.

The control word chooses between two modes. In bare mode the address passes through unchanged and no memory is read. In three-level mode the walk starts at the root table that the control word names. Every entry read goes out on a simple memory port that carries a single-cycle request and returns a response some cycles later. Only one entry read is in flight at any time. At the leaf the block checks the permission bits, and it forms 4 KB, 2 MB or 1 GB mappings.

Top module: `pt_walker`

## Requirements
- R1: When ctl_word[63:60] is 0 (bare), the response carries the virtual address, zero-extended, as the physical address with no fault, and no memory read is issued.
- R2: When ctl_word[63:60] is neither 0 nor 8, the request ends in a fault without any memory read.
- R3: When ctl_word[63:60] is 8, the first entry read is at ctl_word[43:0]*4096 + VA[38:30]*8. Each later read is at the previous entry's bits [53:10]*4096 plus 8 times the next index field, VA[29:21] and then VA[20:12]. There are at most three reads.
- R4: Entry flag positions are V=bit0, R=bit1, W=bit2, X=bit3, U=bit4, D=bit7. An entry with V=0 ends the walk with a fault. An entry with R or X set is a leaf. An entry with R, W and X all zero is a pointer to the next table.
- R5: A pointer entry found at the last level (the VA[20:12] step) gives a fault.
- R6: A leaf at the last level gives the physical address {entry[53:10], VA[11:0]}.
- R7: A leaf at the middle level gives {entry[53:19], VA[20:0]}. A leaf at the top level gives {entry[53:28], VA[29:0]}. If the entry's page-number bits below that split are not all zero, the result is a fault.
- R8: With access code 0 (load) the leaf must have R set. With code 1 (store) it must have W set. With code 2 (fetch) it must have X set. Otherwise the result is a fault.
- R9: A user-mode access to a leaf with U=0 faults. A supervisor access does not need U.
- R10: A store to a leaf with D=0 faults, even when W is set.
- R11: req_ready is high only while the block is idle. Each accepted request produces exactly one single-cycle rsp_valid pulse. mem_req_valid is a single-cycle pulse, and no new pulse is issued before the previous response has arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | High while idle and able to accept a request |
| req_vaddr | input | 39 | Virtual address |
| req_acc | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| req_user | input | 1 | Access comes from user mode |
| ctl_word | input | 64 | Translation control: mode in [63:60], root page number in [43:0] |
| mem_req_valid | output | 1 | Entry read request, one cycle |
| mem_req_addr | output | 56 | Physical byte address of the entry |
| mem_rsp_valid | input | 1 | Entry read data is valid |
| mem_rsp_data | input | 64 | Entry read data |
| rsp_valid | output | 1 | Result strobe, one cycle |
| rsp_paddr | output | 56 | Physical address (meaningful when no fault) |
| rsp_fault | output | 1 | Page fault |

## Verification
A wrong level counter or a wrong table register shows up at the memory port on the very next read, as a wrong address or an extra or missing read. The bench therefore counts the reads for each request and checks the address of the first read. A wrong leaf decision or a wrong permission decision shows up as a wrong fault flag or physical address in the single response cycle that follows the last read. Each request has its own expected result, so one request's error cannot hide behind another's.

// File: rtl/walk_pkg.sv
// Shared constants and types for the page table walker.
// Assumes 4 KB pages, 9-bit index fields and 8-byte entries.
package walk_pkg;
    localparam int VA_W    = 39;
    localparam int PPN_W   = 44;
    localparam int OFF_W   = 12;
    localparam int IDX_W   = 9;
    localparam int LEVELS  = 3;
    localparam int PA_W    = PPN_W + OFF_W;
    localparam int ENT_W   = 64;
    localparam int PPN_LSB = 10;
    localparam int LVL_W   = $clog2(LEVELS);

    localparam int F_V = 0;
    localparam int F_R = 1;
    localparam int F_W = 2;
    localparam int F_X = 3;
    localparam int F_U = 4;
    localparam int F_D = 7;

    localparam logic [3:0] MODE_BARE = 4'd0;
    localparam logic [3:0] MODE_3LVL = 4'd8;

    typedef enum logic [1:0] {ACC_LOAD = 2'd0, ACC_STORE = 2'd1, ACC_FETCH = 2'd2} acc_e;
    typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_DONE} state_e;
endpackage

// File: rtl/ctl_decode.sv
// Splits the translation control word into its mode flags and the root table page number.
// Assumes the mode sits in the top four bits and the page number in the low bits.
module ctl_decode
    import walk_pkg::*;
(
    input  logic [3:0]       mode,
    input  logic [PPN_W-1:0] root_in,
    output logic             is_bare,
    output logic             is_3lvl,
    output logic [PPN_W-1:0] root_ppn
);
    // Decode the mode field into one-hot style flags.
    always_comb begin
        is_bare  = (mode == MODE_BARE);
        is_3lvl  = (mode == MODE_3LVL);
        root_ppn = root_in;
    end
endmodule

// File: rtl/entry_eval.sv
// Judges one page-table entry: fault, leaf or pointer, and forms the leaf address.
// Assumes that level counts down from LEVELS-1 to 0 and that eval marks a live response.
module entry_eval
    import walk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             eval,
    input  logic [ENT_W-1:0] entry,
    input  logic [LVL_W-1:0] level,
    input  acc_e             acc,
    input  logic             user,
    input  logic [VA_W-1:0]  vaddr,
    output logic             is_leaf,
    output logic             fault,
    output logic [PPN_W-1:0] next_ppn,
    output logic [PA_W-1:0]  leaf_pa
);
    localparam int VPN_W = VA_W - OFF_W;

    logic             v, r, w, x, u, d;
    logic             perm_ok, misaligned, reserved;
    logic [PPN_W-1:0] ppn, mask, vpn_ext;

    // Extract flags and the page number from the entry.
    always_comb begin
        v        = entry[F_V];
        r        = entry[F_R];
        w        = entry[F_W];
        x        = entry[F_X];
        u        = entry[F_U];
        d        = entry[F_D];
        ppn      = entry[PPN_LSB +: PPN_W];
        next_ppn = ppn;
        vpn_ext  = PPN_W'(vaddr[VA_W-1:OFF_W]);
    end

    // Build the superpage mask: one index field per level above the last.
    always_comb begin
        mask = '0;
        for (int i = 0; i < LEVELS - 1; i++) begin
            if (LVL_W'(i) < level) mask[i*IDX_W +: IDX_W] = '1;
        end
    end

    // Decide the permission outcome for the requested access kind.
    always_comb begin
        unique case (acc)
            ACC_LOAD:  perm_ok = r;
            ACC_STORE: perm_ok = w & d;
            ACC_FETCH: perm_ok = x;
            default:   perm_ok = 1'b0;
        endcase
        if (user && !u) perm_ok = 1'b0;
    end

    // Classify the entry and form the leaf address.
    always_comb begin
        is_leaf    = r | x;
        reserved   = !r & w;
        misaligned = |(ppn & mask);
        leaf_pa    = {(ppn & ~mask) | (vpn_ext & mask), vaddr[OFF_W-1:0]};
        fault      = !v || reserved ||
                     (is_leaf && (!perm_ok || misaligned)) ||
                     (!is_leaf && level == '0);
    end

    // R4: an invalid entry must never be accepted
    assert_invalid_faults_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (eval && !entry[F_V]) |-> fault);
    // R9: user access to a supervisor page
    assert_user_page_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (eval && entry[F_V] && (entry[F_R] | entry[F_X]) && user && !entry[F_U]) |-> fault);
    // R10: store to a clean page
    assert_clean_store_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (eval && acc == ACC_STORE && !entry[F_D] && (entry[F_R] | entry[F_X])) |-> fault);
    // R5: pointer at the last level
    assert_last_pointer_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (eval && level == '0 && !entry[F_R] && !entry[F_X]) |-> fault);
    // R6: a 4 KB leaf keeps the page offset
    assert_offset_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (eval && !fault && is_leaf) |-> leaf_pa[OFF_W-1:0] == vaddr[OFF_W-1:0]);
endmodule

// File: rtl/pt_walker.sv
// Top of the walker: accepts one request, walks up to three table levels, returns a result.
// Assumes the memory answers every read exactly once and that the requester holds
// the control word stable only for the acceptance cycle.
module pt_walker
    import walk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic [1:0]       req_acc,
    input  logic             req_user,
    input  logic [63:0]      ctl_word,
    output logic             mem_req_valid,
    output logic [PA_W-1:0]  mem_req_addr,
    input  logic             mem_rsp_valid,
    input  logic [ENT_W-1:0] mem_rsp_data,
    output logic             rsp_valid,
    output logic [PA_W-1:0]  rsp_paddr,
    output logic             rsp_fault
);
    state_e           state_q;
    logic [VA_W-1:0]  va_q;
    acc_e             acc_q;
    logic             user_q, bare_q, fault_q;
    logic [LVL_W-1:0] level_q;
    logic [PPN_W-1:0] tbl_q;
    logic [PA_W-1:0]  pa_q;

    logic             is_bare, is_3lvl;
    logic [PPN_W-1:0] root_ppn;
    logic             eval, ent_leaf, ent_fault;
    logic [PPN_W-1:0] ent_next;
    logic [PA_W-1:0]  ent_pa;
    logic [IDX_W-1:0] idx;

    ctl_decode u_dec (
        .mode     (ctl_word[63:60]),
        .root_in  (ctl_word[PPN_W-1:0]),
        .is_bare  (is_bare),
        .is_3lvl  (is_3lvl),
        .root_ppn (root_ppn)
    );

    entry_eval u_eval (
        .clk      (clk),
        .rst_n    (rst_n),
        .eval     (eval),
        .entry    (mem_rsp_data),
        .level    (level_q),
        .acc      (acc_q),
        .user     (user_q),
        .vaddr    (va_q),
        .is_leaf  (ent_leaf),
        .fault    (ent_fault),
        .next_ppn (ent_next),
        .leaf_pa  (ent_pa)
    );

    // Pick the index field for the current level and form the entry address.
    always_comb begin
        idx           = va_q[OFF_W + int'(level_q)*IDX_W +: IDX_W];
        mem_req_addr  = {tbl_q, idx, 3'b000};
        mem_req_valid = (state_q == S_ISSUE);
        req_ready     = (state_q == S_IDLE);
        rsp_valid     = (state_q == S_DONE);
        rsp_paddr     = pa_q;
        rsp_fault     = fault_q;
        eval          = (state_q == S_WAIT) && mem_rsp_valid;
    end

    // Walk sequencer: accept, issue reads, judge responses, report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            va_q    <= '0;
            acc_q   <= ACC_LOAD;
            user_q  <= 1'b0;
            bare_q  <= 1'b0;
            fault_q <= 1'b0;
            level_q <= '0;
            tbl_q   <= '0;
            pa_q    <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: if (req_valid) begin
                    va_q    <= req_vaddr;
                    acc_q   <= acc_e'(req_acc);
                    user_q  <= req_user;
                    bare_q  <= is_bare;
                    level_q <= LVL_W'(LEVELS - 1);
                    tbl_q   <= root_ppn;
                    pa_q    <= PA_W'(req_vaddr);
                    fault_q <= !is_bare && !is_3lvl;
                    state_q <= is_3lvl ? S_ISSUE : S_DONE;
                end
                S_ISSUE: state_q <= S_WAIT;
                S_WAIT: if (mem_rsp_valid) begin
                    if (ent_fault) begin
                        fault_q <= 1'b1;
                        state_q <= S_DONE;
                    end else if (ent_leaf) begin
                        pa_q    <= ent_pa;
                        state_q <= S_DONE;
                    end else begin
                        tbl_q   <= ent_next;
                        level_q <= level_q - 1'b1;
                        state_q <= S_ISSUE;
                    end
                end
                S_DONE: state_q <= S_IDLE;
                default: state_q <= S_IDLE;
            endcase
        end
    end

    // R11: a read request lasts one cycle
    assert_read_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |=> !mem_req_valid);
    // R11: the result strobe lasts one cycle and is followed by readiness
    assert_rsp_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready));
    // R1: bare mode returns the address it was given
    assert_bare_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && bare_q) |-> (!rsp_fault && rsp_paddr == PA_W'(va_q)));
    // R3: level stays in range while walking
    assert_level_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (level_q <= LVL_W'(LEVELS - 1)));
endmodule

// File: tb/sim_pt_walker.sv
module sim_pt_walker;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        req_valid = 0;
    logic        req_ready;
    logic [38:0] req_vaddr = '0;
    logic [1:0]  req_acc = '0;
    logic        req_user = 0;
    logic [63:0] ctl_word = '0;
    logic        mem_req_valid;
    logic [55:0] mem_req_addr;
    logic        mem_rsp_valid = 0;
    logic [63:0] mem_rsp_data = '0;
    logic        rsp_valid;
    logic [55:0] rsp_paddr;
    logic        rsp_fault;

    always #5 clk = ~clk;

    pt_walker u0 (.*);

    typedef struct {
        logic [55:0] pa;
        logic        fault;
        int          reads;
        logic [55:0] first;
        string       tag;
    } item_t;

    item_t q[$];
    int n_chk = 0, n_fail = 0;
    int reads_seen = 0;
    logic [55:0] first_seen = '0;
    bit done = 0;

    localparam logic [63:0] CTL_3L = 64'h8000_0000_0008_1000;

    // Page tables held by the memory model.
    function automatic logic [63:0] ent_at(input logic [55:0] a);
        case (a)
            56'h8100_0000: return (64'h82001 << 10) | 64'h1;
            56'h8100_0008: return 64'h0;
            56'h8200_1000: return (64'h82002 << 10) | 64'h1;
            56'h8200_1008: return (64'h80200 << 10) | 64'hCF;
            56'h8200_1010: return (64'h80201 << 10) | 64'hCF;
            56'h8200_2000: return (64'h80001 << 10) | 64'h7B;
            56'h8200_2008: return (64'h80002 << 10) | 64'hF7;
            56'h8200_2010: return (64'h80003 << 10) | 64'h67;
            56'h8200_2018: return 64'h0;
            56'h8200_2020: return (64'h82003 << 10) | 64'h1;
            default:       return 64'h0;
        endcase
    endfunction

    // Memory model: one-cycle latency response.
    always @(posedge clk) begin
        mem_rsp_valid <= mem_req_valid;
        mem_rsp_data  <= ent_at(mem_req_addr);
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: pushes the expected item, then presents the request.
    task automatic drive(input logic [63:0] ctl, input logic [38:0] va, input logic [1:0] acc,
                         input bit user, input logic [55:0] pa, input bit fault,
                         input int reads, input logic [55:0] first, input string tag);
        item_t it;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        it.pa = pa; it.fault = fault; it.reads = reads; it.first = first; it.tag = tag;
        q.push_back(it);
        ctl_word = ctl; req_vaddr = va; req_acc = acc; req_user = user; req_valid = 1;
        @(negedge clk);
        req_valid = 0;
    endtask

    // Monitor: counts reads and compares each result with the queue head.
    always @(negedge clk) begin
        if (rst_n && mem_req_valid) begin
            if (reads_seen == 0) first_seen = mem_req_addr;
            reads_seen++;
        end
        if (rst_n && rsp_valid) begin
            item_t it;
            if (q.size() == 0) begin
                chk(0, "R11 unexpected response", 64'(rsp_paddr), 64'h0);
            end else begin
                it = q.pop_front();
                chk(rsp_fault == it.fault, {it.tag, " fault"}, 64'(rsp_fault), 64'(it.fault));
                if (!it.fault)
                    chk(rsp_paddr == it.pa, {it.tag, " paddr"}, 64'(rsp_paddr), 64'(it.pa));
                chk(reads_seen == it.reads, {it.tag, " reads"}, 64'(reads_seen), 64'(it.reads));
                if (it.reads > 0)
                    chk(first_seen == it.first, {it.tag, " R3 first addr"}, 64'(first_seen), 64'(it.first));
            end
            reads_seen = 0;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(req_ready == 1, "R11 reset ready", 64'(req_ready), 64'h1);
        chk(rsp_valid == 0, "R11 reset rsp", 64'(rsp_valid), 64'h0);
        chk(mem_req_valid == 0, "R11 reset mem", 64'(mem_req_valid), 64'h0);

        // R6 R8: load and fetch of a 4 KB page
        drive(CTL_3L, 39'h123, 2'd0, 1, 56'h8000_1123, 0, 3, 56'h8100_0000, "R6 load");
        drive(CTL_3L, 39'h0ABC, 2'd2, 1, 56'h8000_1ABC, 0, 3, 56'h8100_0000, "R8 fetch");
        drive(CTL_3L, 39'h123, 2'd1, 1, 56'h0, 1, 3, 56'h8100_0000, "R8 store no W");
        drive(CTL_3L, 39'h1456, 2'd1, 1, 56'h8000_2456, 0, 3, 56'h8100_0000, "R8 store ok");
        drive(CTL_3L, 39'h1456, 2'd2, 1, 56'h0, 1, 3, 56'h8100_0000, "R8 fetch no X");
        // R9: user flag
        drive(CTL_3L, 39'h2010, 2'd0, 1, 56'h0, 1, 3, 56'h8100_0000, "R9 user on S page");
        drive(CTL_3L, 39'h2010, 2'd0, 0, 56'h8000_3010, 0, 3, 56'h8100_0000, "R9 supervisor");
        // R10: clean page store
        drive(CTL_3L, 39'h2010, 2'd1, 0, 56'h0, 1, 3, 56'h8100_0000, "R10 store D=0");
        // R4 R5: invalid and last-level pointer
        drive(CTL_3L, 39'h3000, 2'd0, 0, 56'h0, 1, 3, 56'h8100_0000, "R4 invalid leaf");
        drive(CTL_3L, 39'h4000, 2'd0, 0, 56'h0, 1, 3, 56'h8100_0000, "R5 pointer at last");
        drive(CTL_3L, 39'h4000_0000, 2'd0, 0, 56'h0, 1, 1, 56'h8100_0008, "R4 invalid root");
        // R7: superpages
        drive(CTL_3L, 39'h20_5678, 2'd0, 0, 56'h8020_5678, 0, 2, 56'h8100_0000, "R7 superpage load");
        drive(CTL_3L, 39'h3F_FFFF, 2'd1, 0, 56'h803F_FFFF, 0, 2, 56'h8100_0000, "R7 superpage store");
        drive(CTL_3L, 39'h40_0000, 2'd0, 0, 56'h0, 1, 2, 56'h8100_0000, "R7 misaligned");
        // R1 R2: modes
        drive(64'h0, 39'h7F_1234_5678, 2'd1, 1, 56'h7F_1234_5678, 0, 0, 56'h0, "R1 bare");
        drive(64'h9000_0000_0008_1000, 39'h123, 2'd0, 0, 56'h0, 1, 0, 56'h0, "R2 mode 9");
        drive(64'h0, 39'h0, 2'd0, 0, 56'h0, 0, 0, 56'h0, "R1 bare zero");

        repeat (10) @(negedge clk);
        chk(q.size() == 0, "R11 all answered", 64'(q.size()), 64'h0);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule